// File: doc/BRIEF.md
# Multi-master system bus arbiter

This block is the arbitration unit that sits between one local processor and a system bus shared by several masters. It decodes the processor's status lines to find out when a cycle needs the shared bus and raises a bus request. It wins the bus through a serial priority chain and a shared, wired-AND busy line. While it owns the bus, it enables the processor's bus controller and address latches through an active-low address enable.

Once granted, the arbiter keeps the bus between cycles. Ownership is held across idle periods without further arbitration. Ownership ends only when a surrender condition appears at a point where no shared cycle is running. The surrender conditions are:
- a higher-priority master has taken the priority input away;
- another master is calling on the common request line;
- the processor halts.

Two active-low lock inputs can block surrender. The general lock blocks every kind of surrender. The common-request lock blocks only surrender to common requests.

Several copies are chained. Each copy's priority output feeds the priority input of the next lower copy. All copies share one busy line and one common request line, each wired as an active-low OR of the copies' pull outputs. All inputs are taken as synchronous to the shared bus clock.

Top module: `mm_bus_arbiter`

## Requirements
- R1: While rst_n is low at a clock edge, the block returns to idle, and after that edge it shows aen_n=1 and req_n=1, with busy_pull=0 and cbrq_pull=0.
- R2: The status codes are 3'b111 (passive) and 3'b011 (halt); every other status value is an active cycle. An active cycle is a shared cycle unless resident_mode=1 and bus_sel=0. One clock edge after a shared cycle appears in idle, req_n goes low and cbrq_pull goes high.
- R3: While requesting, the block takes the bus at the first clock edge at which it samples prio_in_n=0 and busy_in_n=1. After that edge, aen_n=0 and busy_pull=1.
- R4: An owner whose processor is passive keeps aen_n=0 for as long as no surrender condition is present. While parked like this, req_n=1.
- R5: An owner gives up the bus when it samples prio_in_n=1 (priority lost), but never while a shared cycle is in progress.
- R6: An owner gives up the bus when it samples cbrq_in_n=0 and crlock_n=1 while no shared cycle is in progress.
- R7: While lock_n=0, an owner never gives up the bus, whatever the cause: priority loss, common request or halt.
- R8: crlock_n=0 blocks only surrender to a common request. Priority loss still releases the bus.
- R9: A halt status with lock_n=1 releases the bus even when no other master is asking for it.
- R10: On surrender, aen_n goes high one edge before busy_pull drops. A new owner therefore asserts aen_n low no earlier than two edges after the old owner's aen_n went high.
- R11: prio_out_n is high when prio_in_n is high, or when the block is requesting, or when it is running a shared cycle as owner. Otherwise prio_out_n is low.
- R12: In resident mode (resident_mode=1), active cycles with bus_sel=0 never request the shared bus.
- R13: In a chain of arbiters sharing busy and common request lines, at most one aen_n is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| resident_mode | input | 1 | Strap: 1 means only cycles with bus_sel high use the shared bus |
| bus_sel | input | 1 | High when the current cycle targets the shared bus (resident mode only) |
| status | input | 3 | Processor status; 3'b111 passive, 3'b011 halt, other values active |
| lock_n | input | 1 | Active-low lock that blocks every surrender |
| crlock_n | input | 1 | Active-low lock that blocks surrender to common requests |
| prio_in_n | input | 1 | Active-low priority grant from the chain above |
| prio_out_n | output | 1 | Active-low priority passed to the next lower arbiter |
| busy_in_n | input | 1 | Shared busy line, low while any master owns the bus |
| busy_pull | output | 1 | High to pull the shared busy line low |
| cbrq_in_n | input | 1 | Shared common request line, low while any master waits |
| cbrq_pull | output | 1 | High to pull the common request line low |
| req_n | output | 1 | Active-low bus request for an external priority resolver |
| aen_n | output | 1 | Active-low address enable to the bus controller and latches |

## Verification
The embedded properties assume that the busy and common request lines are the wired OR of the pull outputs of all chained copies. They also assume that prio_in_n comes from a chain whose top input is tied low, and that the processor holds its status steady while waiting for a grant. The bench keeps to these assumptions in the following ways:
- it wires three copies exactly this way;
- it changes status, lock and select inputs only on falling clock edges;
- it keeps a requesting processor active until its address enable has been seen.

The bench then sweeps every pair of owner and requester, under every combination of the two locks.

// File: rtl/arb_pkg.sv
// Package: shared types for the multi-master bus arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no ownership, no request
        ST_REQ  = 2'd1,   // requesting, waiting for priority and free bus
        ST_HOLD = 2'd2,   // owning the bus, address enable active
        ST_REL  = 2'd3    // address enable dropped, busy still held one cycle
    } arb_state_e;
endpackage

// File: rtl/arb_demand.sv
// Module: arb_demand
// Decodes processor status into "shared cycle in progress" and "halted".
// Assumes: status is stable and synchronous to the bus clock.
module arb_demand #(
    parameter int STATUS_W = 3,
    parameter logic [STATUS_W-1:0] PASSIVE_CODE = 3'b111,
    parameter logic [STATUS_W-1:0] HALT_CODE    = 3'b011
) (
    input  logic [STATUS_W-1:0] status,
    input  logic                resident_mode,
    input  logic                bus_sel,
    output logic                shared_cyc,
    output logic                halt_seen
);
    logic active_cyc;

    // Classify the status code and apply the resident-bus select.
    always_comb begin
        active_cyc = (status != PASSIVE_CODE) && (status != HALT_CODE);
        halt_seen  = (status == HALT_CODE);
        shared_cyc = active_cyc && (!resident_mode || bus_sel);
    end
endmodule

// File: rtl/arb_fsm.sv
// Module: arb_fsm
// Request / grant / park / surrender sequencer of one arbiter.
// Assumes: busy_in_n and cbrq_in_n are wired-OR lines of all arbiters,
// prio_in_n comes from a combinational daisy chain, all synchronous to clk.
module arb_fsm
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shared_cyc,
    input  logic halt_seen,
    input  logic lock_n,
    input  logic crlock_n,
    input  logic prio_in_n,
    input  logic busy_in_n,
    input  logic cbrq_in_n,
    output logic aen_n,
    output logic busy_pull,
    output logic cbrq_pull,
    output logic req_active
);
    arb_state_e state, state_nx;
    logic       give_up;

    // Surrender cause exists and nothing blocks it.
    always_comb begin
        give_up = !shared_cyc && lock_n &&
                  (halt_seen || prio_in_n || (!cbrq_in_n && crlock_n));
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (shared_cyc) state_nx = ST_REQ;
            ST_REQ: begin
                if (!shared_cyc)                   state_nx = ST_IDLE;
                else if (!prio_in_n && busy_in_n)  state_nx = ST_HOLD;
            end
            ST_HOLD: if (give_up) state_nx = ST_REL;
            ST_REL:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output decode from the state register.
    always_comb begin
        aen_n      = (state != ST_HOLD);
        busy_pull  = (state == ST_HOLD) || (state == ST_REL);
        cbrq_pull  = (state == ST_REQ);
        req_active = (state == ST_REQ) || ((state == ST_HOLD) && shared_cyc);
    end

    // R10: busy is only released after a cycle with address enable off.
    a_r10_aen_before_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_pull) |-> $past(aen_n));

    // R3: a grant needs priority and a free bus on the previous edge.
    a_r3_grant_needs_prio: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aen_n) |-> $past(!prio_in_n && busy_in_n));

    // R7: the general lock keeps the bus.
    a_r7_lock_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!aen_n && !lock_n) |=> !aen_n);

    // R5: no surrender in the middle of a shared cycle.
    a_r5_cycle_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!aen_n && shared_cyc) |=> !aen_n);

    // R4: parked ownership is kept while no cause exists.
    a_r4_park_without_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!aen_n && !halt_seen && !prio_in_n && cbrq_in_n) |=> !aen_n);
endmodule

// File: rtl/arb_chain.sv
// Module: arb_chain
// Serial priority pass-through: blocks lower arbiters while this one asks.
// Assumes: chain delay per stage fits within one bus clock period.
module arb_chain (
    input  logic prio_in_n,
    input  logic req_active,
    output logic prio_out_n,
    output logic req_n
);
    // Forward priority only when not requesting or running a shared cycle.
    always_comb begin
        prio_out_n = prio_in_n | req_active;
        req_n      = !req_active;
    end

    // R11: with priority in and no request, priority passes down.
    always_comb begin
        if (!prio_in_n && !req_active)
            a_r11_pass_down: assert (!prio_out_n);
    end
endmodule

// File: rtl/mm_bus_arbiter.sv
// Module: mm_bus_arbiter
// One arbiter of a multi-master system bus: status decode, sequencer and
// serial priority stage.
// Assumes: one bus clock for all arbiters, synchronous active-low reset.
module mm_bus_arbiter #(
    parameter int STATUS_W = 3,
    parameter logic [STATUS_W-1:0] PASSIVE_CODE = 3'b111,
    parameter logic [STATUS_W-1:0] HALT_CODE    = 3'b011
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                resident_mode,
    input  logic                bus_sel,
    input  logic [STATUS_W-1:0] status,
    input  logic                lock_n,
    input  logic                crlock_n,
    input  logic                prio_in_n,
    output logic                prio_out_n,
    input  logic                busy_in_n,
    output logic                busy_pull,
    input  logic                cbrq_in_n,
    output logic                cbrq_pull,
    output logic                req_n,
    output logic                aen_n
);
    logic shared_cyc;
    logic halt_seen;
    logic req_active;

    arb_demand #(
        .STATUS_W     (STATUS_W),
        .PASSIVE_CODE (PASSIVE_CODE),
        .HALT_CODE    (HALT_CODE)
    ) u_demand (
        .status        (status),
        .resident_mode (resident_mode),
        .bus_sel       (bus_sel),
        .shared_cyc    (shared_cyc),
        .halt_seen     (halt_seen)
    );

    arb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .shared_cyc (shared_cyc),
        .halt_seen  (halt_seen),
        .lock_n     (lock_n),
        .crlock_n   (crlock_n),
        .prio_in_n  (prio_in_n),
        .busy_in_n  (busy_in_n),
        .cbrq_in_n  (cbrq_in_n),
        .aen_n      (aen_n),
        .busy_pull  (busy_pull),
        .cbrq_pull  (cbrq_pull),
        .req_active (req_active)
    );

    arb_chain u_chain (
        .prio_in_n  (prio_in_n),
        .req_active (req_active),
        .prio_out_n (prio_out_n),
        .req_n      (req_n)
    );

    // R12: a resident cycle never raises a fresh request.
    a_r12_resident_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (aen_n && req_n && resident_mode && !bus_sel) |=> req_n);
endmodule

// File: tb/mm_bus_arbiter_tb.sv
// Bench: three chained arbiters on shared busy / common request lines.
module mm_bus_arbiter_tb;
    localparam int N = 3;
    localparam logic [2:0] PASV = 3'b111;
    localparam logic [2:0] HALT = 3'b011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] st [N];
    logic [N-1:0] res_mode, bsel, lock_n, crlock_n;
    logic [N-1:0] prio_in_n, prio_out_n, busy_pull, cbrq_pull, req_n, aen_n;
    logic busy_in_n, cbrq_in_n;
    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign busy_in_n = ~|busy_pull;
    assign cbrq_in_n = ~|cbrq_pull;

    for (genvar i = 0; i < N; i++) begin : g_arb
        if (i == 0) begin : g_top
            assign prio_in_n[i] = 1'b0;
        end else begin : g_low
            assign prio_in_n[i] = prio_out_n[i-1];
        end
        mm_bus_arbiter u_dut (
            .clk           (clk),
            .rst_n         (rst_n),
            .resident_mode (res_mode[i]),
            .bus_sel       (bsel[i]),
            .status        (st[i]),
            .lock_n        (lock_n[i]),
            .crlock_n      (crlock_n[i]),
            .prio_in_n     (prio_in_n[i]),
            .prio_out_n    (prio_out_n[i]),
            .busy_in_n     (busy_in_n),
            .busy_pull     (busy_pull[i]),
            .cbrq_in_n     (cbrq_in_n),
            .cbrq_pull     (cbrq_pull[i]),
            .req_n         (req_n[i]),
            .aen_n         (aen_n[i])
        );
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < N; i++) st[i] = PASV;
        res_mode = '0; bsel = '0; lock_n = '1; crlock_n = '1;
        tick(2);
        rst_n = 1'b1;
    endtask

    // Take the bus for arbiter h and park it.
    task automatic own(input int h, input logic [2:0] code);
        st[h] = code;
        tick(2);
        chk(aen_n[h] == 1'b0, "R3 grant", aen_n[h], 0);
    endtask

    // R13: mutual exclusion monitor across the chain.
    always @(negedge clk) begin
        if (rst_n) begin
            n_checks++;
            if ($countones(~aen_n) > 1) begin
                n_fails++;
                $display("FAIL R13 enables actual=%0d expected<=1", $countones(~aen_n));
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 150000);
        n_fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [2:0] codes [6];
        int idx;
        codes[0] = 3'b000; codes[1] = 3'b001; codes[2] = 3'b010;
        codes[3] = 3'b100; codes[4] = 3'b101; codes[5] = 3'b110;

        // R1: reset state.
        do_reset();
        chk(aen_n == 3'b111, "R1 aen_n", aen_n, 7);
        chk(req_n == 3'b111, "R1 req_n", req_n, 7);
        chk(busy_pull == 3'b000 && cbrq_pull == 3'b000, "R1 pulls",
            {busy_pull, cbrq_pull}, 0);
        chk(prio_out_n[0] == 1'b0, "R11 idle passes", prio_out_n[0], 0);

        // Sweep: holder h, requester r, lock and common-request lock.
        idx = 0;
        for (int h = 0; h < N; h++) begin
            for (int r = 0; r < N; r++) begin
                if (r == h) continue;
                for (int lk = 0; lk < 2; lk++) begin
                    for (int cl = 0; cl < 2; cl++) begin
                        bit blocked;
                        blocked = (lk == 0) || (cl == 0 && r > h);
                        do_reset();
                        own(h, codes[idx % 6]);
                        st[h] = PASV;
                        lock_n[h] = lk[0];
                        crlock_n[h] = cl[0];
                        tick(1);
                        chk(aen_n[h] == 1'b0 && req_n[h] == 1'b1, "R4 park",
                            {aen_n[h], req_n[h]}, 1);
                        st[r] = codes[(idx + 1) % 6];
                        tick(1);
                        chk(req_n[r] == 1'b0 && cbrq_pull[r] == 1'b1, "R2 request",
                            {req_n[r], cbrq_pull[r]}, 1);
                        if (blocked) begin
                            tick(4);
                            chk(aen_n[h] == 1'b0 && aen_n[r] == 1'b1,
                                (lk == 0) ? "R7 lock holds" : "R8 crlock holds",
                                {aen_n[h], aen_n[r]}, 1);
                            lock_n[h] = 1'b1;
                            crlock_n[h] = 1'b1;
                            tick(1);
                        end else begin
                            tick(1);
                            chk(aen_n[h] == 1'b1,
                                (r < h) ? "R5 priority loss" : "R6 common request",
                                aen_n[h], 1);
                        end
                        chk(busy_pull[h] == 1'b1, "R10 busy held", busy_pull[h], 1);
                        tick(1);
                        chk(busy_pull[h] == 1'b0 && aen_n[r] == 1'b1, "R10 gap",
                            {busy_pull[h], aen_n[r]}, 1);
                        tick(1);
                        chk(aen_n[r] == 1'b0, "R3 handover", aen_n[r], 0);
                        idx++;
                    end
                end
            end
        end

        // R5: no surrender during a shared cycle.
        do_reset();
        own(1, 3'b100);
        st[0] = 3'b101;
        tick(1);
        chk(prio_out_n[0] == 1'b1, "R11 requester blocks", prio_out_n[0], 1);
        tick(4);
        chk(aen_n[1] == 1'b0 && aen_n[0] == 1'b1, "R5 mid-cycle", {aen_n[1], aen_n[0]}, 1);
        st[1] = PASV;
        tick(1);
        chk(aen_n[1] == 1'b1, "R5 after cycle", aen_n[1], 1);
        tick(2);
        chk(aen_n[0] == 1'b0, "R5 new owner", aen_n[0], 0);
        st[0] = PASV;
        tick(1);
        chk(prio_out_n[0] == 1'b0, "R11 parked passes", prio_out_n[0], 0);

        // R7 with halt, then R9 halt surrender.
        do_reset();
        own(2, 3'b110);
        lock_n[2] = 1'b0;
        st[2] = HALT;
        tick(4);
        chk(aen_n[2] == 1'b0, "R7 halt locked", aen_n[2], 0);
        lock_n[2] = 1'b1;
        tick(1);
        chk(aen_n[2] == 1'b1, "R9 halt release", aen_n[2], 1);
        tick(1);
        chk(busy_pull[2] == 1'b0, "R9 busy free", busy_pull[2], 0);

        // R12: resident mode.
        do_reset();
        res_mode[0] = 1'b1;
        st[0] = 3'b010;
        tick(3);
        chk(req_n[0] == 1'b1 && aen_n[0] == 1'b1, "R12 resident cycle",
            {req_n[0], aen_n[0]}, 3);
        bsel[0] = 1'b1;
        tick(1);
        chk(req_n[0] == 1'b0, "R12 shared select", req_n[0], 0);
        tick(1);
        chk(aen_n[0] == 1'b0, "R12 grant", aen_n[0], 0);
        bsel[0] = 1'b0;
        tick(1);
        chk(req_n[0] == 1'b1 && aen_n[0] == 1'b0, "R12 resident while owning",
            {req_n[0], aen_n[0]}, 2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule